// File: doc/BRIEF.md
# Fixed-Weight RGB to Grayscale Converter

This block turns a stream of RGB pixels, 8 bits per channel, into an 8-bit luma value. It uses the standard-definition television luma weights: about 0.299 for red, 0.587 for green and 0.114 for blue. Each weight is held as a 9-bit fraction of 512: red 153, green 301 and blue 58. These three numbers add up to exactly 512. Each product is built from shifted copies of the channel value that are then added. The block uses no hardware multiplier and no floating point.

One pixel can enter on every clock, marked by a valid bit. There is no backpressure. The gray value leaves two clocks later with its own valid bit, so gaps in the input stream are kept as they are. A build-time parameter chooses how the sum is reduced to 8 bits. Rounding adds half an output step before the top bits are taken. Truncation simply drops the low bits.

Top module: `rgb_to_gray`

## Requirements
- R1: With ROUND=1, for every valid pixel, out_gray equals floor((153*R + 301*G + 58*B + 256) / 512).
- R2: With ROUND=0, for every valid pixel, out_gray equals floor((153*R + 301*G + 58*B) / 512).
- R3: White (255,255,255) gives 255 in both modes. The rounded 17-bit sum never carries into an 18th bit.
- R4: A pixel whose three channels all equal v gives exactly v in both modes. Black (0,0,0) gives 0.
- R5: out_valid is in_valid delayed by exactly 2 clocks. A cycle with in_valid low gives a cycle with out_valid low 2 clocks later.
- R6: While rst is high, and on the first clock after it falls, out_valid is 0. Only the valid pipeline is reset.
- R7: Pixels presented on consecutive clocks come out on consecutive clocks, one per clock, in input order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst | input | 1 | Synchronous, active-high reset of the valid pipeline |
| in_valid | input | 1 | Marks in_r, in_g, in_b as a pixel this clock |
| in_r | input | 8 | Red channel, unsigned |
| in_g | input | 8 | Green channel, unsigned |
| in_b | input | 8 | Blue channel, unsigned |
| out_valid | output | 1 | Marks out_gray as a result this clock |
| out_gray | output | 8 | Luma value, unsigned |

## Verification
The bench drives two copies of the block at once, one rounding and one truncating. Both copies are checked against an integer model. This exposes a wrong weight or a missing shift-add term, which shifts results for some channel values. It also exposes rounding applied to the wrong build, which moves outputs by one exactly where the low nine bits of the sum cross 256. Full-scale white and an equal-channel ramp target a sum width one bit too short, which would wrap 255 to a small value. Bursts, single-cycle gaps and a reset in the middle of a stream target a valid pipe of the wrong depth, which would shift or smear the valid pattern against the data.

// File: rtl/gray_pkg.sv
package gray_pkg;
    // Channel and weight geometry shared by the converter
    localparam int unsigned PIX_W  = 8;
    localparam int unsigned COEF_W = 9;
    // Luma weights as fractions of 2**COEF_W; they sum to exactly 2**COEF_W
    localparam int unsigned K_RED  = 153;
    localparam int unsigned K_GRN  = 301;
    localparam int unsigned K_BLU  = 58;
endpackage

// File: rtl/gray_cmul.sv
// Constant-coefficient multiplier: one shifted copy of the input per set bit
module gray_cmul #(
    parameter int unsigned PIX_W  = 8,
    parameter int unsigned COEF_W = 9,
    parameter int unsigned COEF   = 153,
    parameter int unsigned PROD_W = PIX_W + $clog2(COEF + 1)
) (
    input  logic [PIX_W-1:0]  pix,
    output logic [PROD_W-1:0] prod
);
    logic [PROD_W-1:0] term [COEF_W];

    for (genvar i = 0; i < COEF_W; i++) begin : g_term
        if (COEF[i]) begin : g_on
            assign term[i] = PROD_W'(pix) << i;
        end else begin : g_off
            assign term[i] = '0;
        end
    end

    always_comb begin
        prod = '0;
        for (int i = 0; i < COEF_W; i++) begin
            prod = prod + term[i];
        end
    end
endmodule

// File: rtl/gray_sum.sv
// Adds the three weighted channels, applies optional half-step rounding,
// and slices the output byte from the top of the sum.
module gray_sum #(
    parameter int unsigned PIX_W  = 8,
    parameter int unsigned COEF_W = 9,
    parameter int unsigned PR_W   = 16,
    parameter int unsigned PG_W   = 17,
    parameter int unsigned PB_W   = 14,
    parameter bit          ROUND  = 1'b1,
    parameter int unsigned SUM_W  = PIX_W + COEF_W
) (
    input  logic [PR_W-1:0]  pr,
    input  logic [PG_W-1:0]  pg,
    input  logic [PB_W-1:0]  pb,
    output logic [SUM_W:0]   total,
    output logic [PIX_W-1:0] gray
);
    localparam logic [SUM_W:0] HALF = ROUND ? (SUM_W+1)'(1) << (COEF_W - 1) : '0;

    always_comb begin
        total = (SUM_W+1)'(pr) + (SUM_W+1)'(pg) + (SUM_W+1)'(pb) + HALF;
        gray  = total[SUM_W-1 -: PIX_W];
    end
endmodule

// File: rtl/rgb_to_gray.sv
module rgb_to_gray #(
    parameter int unsigned PIX_W  = gray_pkg::PIX_W,
    parameter int unsigned COEF_W = gray_pkg::COEF_W,
    parameter int unsigned K_R    = gray_pkg::K_RED,
    parameter int unsigned K_G    = gray_pkg::K_GRN,
    parameter int unsigned K_B    = gray_pkg::K_BLU,
    parameter bit          ROUND  = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [PIX_W-1:0] in_r,
    input  logic [PIX_W-1:0] in_g,
    input  logic [PIX_W-1:0] in_b,
    output logic             out_valid,
    output logic [PIX_W-1:0] out_gray
);
    localparam int unsigned PR_W  = PIX_W + $clog2(K_R + 1);
    localparam int unsigned PG_W  = PIX_W + $clog2(K_G + 1);
    localparam int unsigned PB_W  = PIX_W + $clog2(K_B + 1);
    localparam int unsigned SUM_W = PIX_W + COEF_W;

    typedef struct packed {
        logic            vld;
        logic [PR_W-1:0] pr;
        logic [PG_W-1:0] pg;
        logic [PB_W-1:0] pb;
    } prod_stage_t;

    typedef struct packed {
        logic             vld;
        logic [PIX_W-1:0] gray;
    } out_stage_t;

    prod_stage_t prod_d, prod_q;
    out_stage_t  out_d,  out_q;

    logic [PR_W-1:0]  pr_c;
    logic [PG_W-1:0]  pg_c;
    logic [PB_W-1:0]  pb_c;
    logic [SUM_W:0]   total_c;
    logic [PIX_W-1:0] gray_c;

    gray_cmul #(.PIX_W(PIX_W), .COEF_W(COEF_W), .COEF(K_R), .PROD_W(PR_W)) u_mul_r (
        .pix(in_r), .prod(pr_c));
    gray_cmul #(.PIX_W(PIX_W), .COEF_W(COEF_W), .COEF(K_G), .PROD_W(PG_W)) u_mul_g (
        .pix(in_g), .prod(pg_c));
    gray_cmul #(.PIX_W(PIX_W), .COEF_W(COEF_W), .COEF(K_B), .PROD_W(PB_W)) u_mul_b (
        .pix(in_b), .prod(pb_c));

    gray_sum #(
        .PIX_W(PIX_W), .COEF_W(COEF_W), .PR_W(PR_W), .PG_W(PG_W), .PB_W(PB_W),
        .ROUND(ROUND), .SUM_W(SUM_W)
    ) u_sum (
        .pr(prod_q.pr), .pg(prod_q.pg), .pb(prod_q.pb),
        .total(total_c), .gray(gray_c));

    always_comb begin
        prod_d.vld = in_valid;
        prod_d.pr  = pr_c;
        prod_d.pg  = pg_c;
        prod_d.pb  = pb_c;
        out_d.vld  = prod_q.vld;
        out_d.gray = gray_c;
    end

    // Data fields carry no reset; only the valid bits are cleared
    always_ff @(posedge clk) begin
        prod_q <= prod_d;
        out_q  <= out_d;
        if (rst) begin
            prod_q.vld <= 1'b0;
            out_q.vld  <= 1'b0;
        end
    end

    assign out_valid = out_q.vld;
    assign out_gray  = out_q.gray;

    // R3: rounded sum fits the accumulator
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        prod_q.vld |-> !total_c[SUM_W]);

    // R3: full-scale white maps to full-scale gray
    assert_white_full_R3: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(in_valid && (&in_r) && (&in_g) && (&in_b), 2))
        |-> (&out_gray));

    // R4: equal channels pass through unchanged
    assert_equal_chan_R4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(in_valid && in_r == in_g && in_g == in_b, 2))
        |-> out_gray == $past(in_r, 2));

    // R5: valid pipe depth of two
    assert_valid_lat_R5: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ##2 out_valid);

    assert_gap_lat_R5: assert property (@(posedge clk) disable iff (rst)
        !in_valid |-> ##2 !out_valid);

    // R6: reset empties the output valid
    assert_reset_clear_R6: assert property (@(posedge clk)
        rst |=> !out_valid);
endmodule

// File: tb/rgb_to_gray_tb.sv
module rgb_to_gray_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_r = '0, in_g = '0, in_b = '0;
    logic       ov_rnd, ov_trn;
    logic [7:0] gy_rnd, gy_trn;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    typedef struct {
        bit    v;
        int    g_rnd;
        int    g_trn;
        string tag_v;
        string tag_r;
        string tag_t;
    } exp_t;

    exp_t q[$];

    always #2 clk = ~clk;  // 250 MHz

    rgb_to_gray #(.ROUND(1'b1)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .in_r(in_r), .in_g(in_g), .in_b(in_b),
        .out_valid(ov_rnd), .out_gray(gy_rnd));

    rgb_to_gray #(.ROUND(1'b0)) u_dut_trunc (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .in_r(in_r), .in_g(in_g), .in_b(in_b),
        .out_valid(ov_trn), .out_gray(gy_trn));

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare what is due this cycle, then present the next input
    task automatic step(input bit v, input int r, input int g, input int b,
                        input bit burst);
        exp_t e;
        int   acc;
        @(negedge clk);
        if (q.size() == 2) begin
            e = q.pop_front();
            check(e.tag_v, ov_rnd, e.v);
            check(e.tag_v, ov_trn, e.v);
            if (e.v) begin
                check(e.tag_r, gy_rnd, e.g_rnd);
                check(e.tag_t, gy_trn, e.g_trn);
            end
        end
        in_valid = v;
        in_r = 8'(r); in_g = 8'(g); in_b = 8'(b);
        acc = 153 * r + 301 * g + 58 * b;
        e.v     = v;
        e.g_rnd = (acc + 256) / 512;
        e.g_trn = acc / 512;
        e.tag_v = burst ? "R7 valid" : "R5 valid";
        if (r == 255 && g == 255 && b == 255) begin
            e.tag_r = "R3 white";   e.tag_t = "R3 white";
        end else if (r == g && g == b) begin
            e.tag_r = "R4 equal";   e.tag_t = "R4 equal";
        end else begin
            e.tag_r = "R1 round";   e.tag_t = "R2 trunc";
        end
        q.push_back(e);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        q.delete();
        repeat (3) @(negedge clk);
        check("R6 reset valid", ov_rnd, 0);
        check("R6 reset valid", ov_trn, 0);
        rst = 1'b0;
    endtask

    initial begin : stim
        int r, g, b;
        in_valid = 1'b1;              // valid held high during reset
        in_r = 8'hff; in_g = 8'hff; in_b = 8'hff;
        repeat (3) @(negedge clk);
        check("R6 reset valid", ov_rnd, 0);
        check("R6 reset valid", ov_trn, 0);
        rst = 1'b0;
        in_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R6 first clock after reset", ov_rnd, 0);

        // Black, white, primaries
        step(1, 0, 0, 0, 0);
        step(1, 255, 255, 255, 0);
        step(0, 0, 0, 0, 0);
        step(1, 255, 0, 0, 0);
        step(1, 0, 255, 0, 0);
        step(1, 0, 0, 255, 0);
        step(1, 255, 255, 0, 0);
        step(1, 0, 255, 255, 0);
        // R1/R2 rounding boundary: 153 stays 0, 306 splits modes
        step(1, 1, 0, 0, 0);
        step(1, 2, 0, 0, 0);
        step(1, 0, 1, 0, 0);
        step(1, 0, 0, 5, 0);
        step(0, 0, 0, 0, 0);

        // R4 equal-channel ramp, back to back (R7)
        for (int v = 0; v < 256; v++) step(1, v, v, v, 1);
        step(0, 0, 0, 0, 0);

        // Random pixels with random gaps (R1, R2, R5)
        for (int i = 0; i < 3000; i++) begin
            r = $urandom_range(0, 255);
            g = $urandom_range(0, 255);
            b = $urandom_range(0, 255);
            step(($urandom_range(0, 3) != 0), r, g, b, 0);
        end

        // Alternating single-cycle gaps (R5)
        for (int i = 0; i < 40; i++) step(i % 2, i * 6, 255 - i, i, 0);

        // Reset in mid-stream, then resume (R6)
        step(1, 10, 20, 30, 0);
        step(1, 40, 50, 60, 0);
        do_reset();
        @(negedge clk);
        check("R6 first clock after reset", ov_rnd, 0);
        check("R6 first clock after reset", ov_trn, 0);
        for (int i = 0; i < 64; i++) step(1, 255 - i, i * 3, i * 2, 1);
        repeat (3) step(0, 0, 0, 0, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule